// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a synchronous host-side controller for an asynchronous, byte-wide static RAM of 2,097,152 bytes (21 address lines, 8 data lines). The host issues one single-byte read or write at a time through a valid/ready port that carries a direction flag, an address and write data. The controller runs the memory cycle on active-low chip-select, output-enable and write-strobe lines, and it returns read data with a one-cycle done pulse.

Every timing window is a whole number of clock cycles. Each is derived at elaboration from a nanosecond limit and the clock period in picoseconds: the count is the ceiling of the limit divided by the period, and never less than one. The data bus appears as three plain signals: an output value, a drive-enable for an external tristate buffer, and an input value. The controller drives the bus only during a write and its recovery gap. Output enable stays high for the whole of a write, so the two sides never fight over the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: A request is accepted only at a clock edge where req_valid and req_ready are both 1. req_ready is 1 only while idle, so it falls the cycle after acceptance and rises again in the rsp_done cycle. A request presented while busy is ignored and leaves the memory unchanged.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1, with mem_addr equal to the request address, for RD cycles. RD is the largest of ceil(T_ACC_NS), ceil(T_CE_NS) and ceil(T_OE_NS) in clock periods. With the defaults (100, 100, 50 ns at 5000 ps) RD is 20.
- R4: Read data is sampled on the edge that ends the read window. It appears on rsp_rdata in the cycle where rsp_done is 1, and rsp_done lasts exactly one cycle.
- R5: A write holds mem_ce_n=0 and mem_we_n=0 together for WP cycles. WP is the larger of ceil(T_WP_NS) and ceil(T_DS_NS): 15 with the defaults (75 and 40 ns). mem_oe_n stays 1 through the strobe and the recovery gap.
- R6: After mem_we_n rises, all strobes stay 1 for REC cycles before rsp_done. REC is the larger of ceil(T_WR_NS) and ceil(T_WC_NS) minus WP: 5 with the defaults (10 and 100 ns). In the rsp_done cycle mem_dq_oe is 0 and req_ready is 1.
- R7: Through the write strobe and the recovery gap, mem_addr holds the request address, mem_dq_out holds the write data and mem_dq_oe is 1.
- R8: mem_dq_oe is 0 in every cycle where mem_oe_n is 0 and in the cycle just before it, so a read that directly follows a write finds the bus released.
- R9: Every window count is the ceiling of its limit over the clock period, with a minimum of one. At a 200000 ps period every window is one cycle. rsp_done then shows in the second cycle after acceptance for a read and in the third for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data, valid with rsp_done |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 21 | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Value read from the data bus |

## Verification
The bench builds one instance with the default 5000 ps period. That gives multi-cycle windows of 20 read, 15 strobe and 5 recovery cycles, so exact window lengths, back-to-back read-after-write bus release and rejection of requests made mid-write can all be observed. A second instance uses a 200000 ps period. There every limit rounds to one cycle or below, which brings the minimum-of-one clamp and the recovery term (which would otherwise be zero or negative) within reach through the done latency.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ    = 2'd1,
    ST_WSTROBE = 2'd2,
    ST_WREC    = 2'd3
  } sram_st_e;

  // Ceiling of a nanosecond limit over a picosecond period, never below one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ps);
    int unsigned whole;
    whole = (ns * 1000) / clk_ps;
    if (((ns * 1000) % clk_ps) != 0) whole = whole + 1;
    if (whole == 0) whole = 1;
    return whole;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Recovery gap: the write-recovery limit, or whatever remains of the full write cycle.
  function automatic int unsigned rec_cycles(input int unsigned wr_ns, input int unsigned wc_ns,
                                             input int unsigned wp_cyc, input int unsigned clk_ps);
    int unsigned wc_cyc;
    int unsigned rest;
    wc_cyc = ns_to_cycles(wc_ns, clk_ps);
    rest   = (wc_cyc > wp_cyc) ? (wc_cyc - wp_cyc) : 0;
    return max2(ns_to_cycles(wr_ns, clk_ps), rest);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_regs.sv
module sram_bus_regs #(
  parameter int unsigned AW = 21,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_rd,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_rd) rdata_q <= dq_in;
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 21,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_ACC_NS  = 100,
  parameter int unsigned T_CE_NS   = 100,
  parameter int unsigned T_OE_NS   = 50,
  parameter int unsigned T_WP_NS   = 75,
  parameter int unsigned T_DS_NS   = 40,
  parameter int unsigned T_WC_NS   = 100,
  parameter int unsigned T_WR_NS   = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC  = max2(ns_to_cycles(T_ACC_NS, CLK_PS),
                                    max2(ns_to_cycles(T_CE_NS, CLK_PS), ns_to_cycles(T_OE_NS, CLK_PS)));
  localparam int unsigned WP_CYC  = max2(ns_to_cycles(T_WP_NS, CLK_PS), ns_to_cycles(T_DS_NS, CLK_PS));
  localparam int unsigned REC_CYC = rec_cycles(T_WR_NS, T_WC_NS, WP_CYC, CLK_PS);
  localparam int unsigned MAX_CYC = max2(RD_CYC, max2(WP_CYC, REC_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  sram_st_e         st_q, st_nx;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  // Named internal events
  logic accept, rd_sample, wr_strobe_end, wr_done;
  assign accept        = req_valid && (st_q == ST_IDLE);
  assign rd_sample     = (st_q == ST_READ)    && tmr_expired;
  assign wr_strobe_end = (st_q == ST_WSTROBE) && tmr_expired;
  assign wr_done       = (st_q == ST_WREC)    && tmr_expired;

  always_comb begin
    st_nx    = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        st_nx    = req_we ? ST_WSTROBE : ST_READ;
        tmr_val  = req_we ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_READ:    if (rd_sample) st_nx = ST_IDLE;
      ST_WSTROBE: if (wr_strobe_end) begin
        st_nx    = ST_WREC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WREC:    if (wr_done) st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next state so the memory sees glitch-free lines.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
    end else begin
      st_q      <= st_nx;
      mem_ce_n  <= !((st_nx == ST_READ) || (st_nx == ST_WSTROBE));
      mem_oe_n  <= !(st_nx == ST_READ);
      mem_we_n  <= !(st_nx == ST_WSTROBE);
      mem_dq_oe <= (st_nx == ST_WSTROBE) || (st_nx == ST_WREC);
      rsp_done  <= rd_sample || wr_done;
    end
  end

  assign req_ready = (st_q == ST_IDLE);

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_bus_regs #(.AW(AW), .DW(DW)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_req   (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cap_rd    (rd_sample),
    .dq_in     (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (rsp_rdata)
  );

  // Length of the current write-strobe low period, for the pulse-width check.
  logic [CNT_W-1:0] we_low_len;
  always_ff @(posedge clk) begin
    if (!rst_n)        we_low_len <= '0;
    else if (mem_we_n) we_low_len <= '0;
    else               we_low_len <= we_low_len + 1'b1;
  end

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n)); // R2
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R5
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_len == CNT_W'(WP_CYC))); // R5
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (mem_ce_n && !mem_dq_oe)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_addr)); // R7
  AST_BUS_FREE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe))); // R8
endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int AW = 21;
  localparam int DW = 8;
  localparam int CLK_PS = 5000;
  localparam int SLOW_PS = 200000;
  // Expected window lengths, worked out from the requirements.
  localparam int RD_EXP  = (100 * 1000 + CLK_PS - 1) / CLK_PS;            // 20
  localparam int WP_EXP  = (75 * 1000 + CLK_PS - 1) / CLK_PS;             // 15
  localparam int WC_EXP  = (100 * 1000 + CLK_PS - 1) / CLK_PS;            // 20
  localparam int WR_EXP  = (10 * 1000 + CLK_PS - 1) / CLK_PS;             // 2
  localparam int REC_EXP = (WC_EXP - WP_EXP > WR_EXP) ? WC_EXP - WP_EXP : WR_EXP; // 5

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n;

  logic          req_valid, req_ready, req_we, rsp_done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, mem_dq_out, mem_dq_in;

  sram_async_ctrl #(.AW(AW), .DW(DW), .CLK_PS(CLK_PS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  // Second build: every window collapses to one cycle.
  logic          s_valid, s_ready, s_we, s_done, s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [AW-1:0] s_addr, s_maddr;
  logic [DW-1:0] s_wdata, s_rdata, s_dq_out, s_dq_in;

  sram_async_ctrl #(.AW(AW), .DW(DW), .CLK_PS(SLOW_PS)) dut_slow (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready), .req_we(s_we),
    .req_addr(s_addr), .req_wdata(s_wdata), .rsp_rdata(s_rdata), .rsp_done(s_done),
    .mem_addr(s_maddr), .mem_ce_n(s_ce_n), .mem_oe_n(s_oe_n), .mem_we_n(s_we_n),
    .mem_dq_out(s_dq_out), .mem_dq_oe(s_dq_oe), .mem_dq_in(s_dq_in));
  assign s_dq_in = (!s_ce_n && !s_oe_n) ? (s_maddr[7:0] ^ 8'h5A) : 8'h00;

  // Memory model: 256 bytes indexed by the low address bits.
  logic [7:0] model_mem [256];
  logic [7:0] exp_mem   [256];
  always @(posedge clk) if (!mem_ce_n && !mem_we_n) model_mem[mem_addr[7:0]] <= mem_dq_out;
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? model_mem[mem_addr[7:0]] : 8'h00;

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed { logic we; logic [AW-1:0] addr; logic [DW-1:0] data; } op_t;
  op_t sb_q[$];

  // Driver: called at a negedge; pushes the expected outcome.
  task automatic issue(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    op_t op;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = data;
    op.we = we; op.addr = addr;
    if (we) begin op.data = data; exp_mem[addr[7:0]] = data; end
    else    op.data = exp_mem[addr[7:0]];
    sb_q.push_back(op);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low after accept", int'(req_ready), 0);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!rsp_done);
  endtask

  task automatic op_run(input bit we, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    issue(we, addr, data);
    wait_done();
  endtask

  // Monitor / scoreboard
  bit mon_en = 0;
  int we_len = 0, oe_len = 0, rec_len = 0;
  bit in_rec = 0, prev_oe = 1, prev_we = 1, prev_dq_oe = 0;
  always @(negedge clk) if (mon_en) begin
    if (!mem_oe_n) begin
      oe_len++;
      chk(!mem_dq_oe && !prev_dq_oe, "R8 bus released around read", int'(mem_dq_oe), 0);
      chk(mem_we_n && !mem_ce_n, "R3 read strobes", int'({mem_ce_n, mem_we_n}), 1);
      if (sb_q.size() > 0) chk(mem_addr == sb_q[0].addr, "R3 read address", int'(mem_addr), int'(sb_q[0].addr));
    end else if (!prev_oe) begin
      chk(oe_len == RD_EXP, "R3 read window", oe_len, RD_EXP);
      oe_len = 0;
    end
    if (!mem_we_n) begin
      we_len++;
      chk(mem_oe_n && !mem_ce_n, "R5 strobes in write", int'({mem_ce_n, mem_oe_n}), 1);
      if (sb_q.size() > 0)
        chk(mem_dq_oe && mem_dq_out == sb_q[0].data && mem_addr == sb_q[0].addr,
            "R7 write data/address", int'(mem_dq_out), int'(sb_q[0].data));
    end else if (!prev_we) begin
      chk(we_len == WP_EXP, "R5 strobe width", we_len, WP_EXP);
      we_len = 0; rec_len = 1; in_rec = 1;
    end else if (in_rec && !rsp_done) begin
      rec_len++;
      if (sb_q.size() > 0)
        chk(mem_dq_oe && mem_oe_n && mem_ce_n && mem_addr == sb_q[0].addr && mem_dq_out == sb_q[0].data,
            "R7 hold in recovery", int'(mem_dq_out), int'(sb_q[0].data));
    end
    if (rsp_done) begin
      if (sb_q.size() == 0) chk(1'b0, "R2 done without request", 1, 0);
      else begin
        op_t op;
        op = sb_q.pop_front();
        if (op.we) begin
          chk(rec_len == REC_EXP, "R6 recovery length", rec_len, REC_EXP);
          chk(!mem_dq_oe, "R6 bus released at done", int'(mem_dq_oe), 0);
          in_rec = 0;
        end else begin
          chk(rsp_rdata == op.data, "R4 read data", int'(rsp_rdata), int'(op.data));
        end
        chk(req_ready, "R6 ready at done", int'(req_ready), 1);
      end
    end
    prev_oe = mem_oe_n; prev_we = mem_we_n; prev_dq_oe = mem_dq_oe;
  end

  // Slow-build transaction with measured latency.
  task automatic slow_op(input bit we, input logic [AW-1:0] addr, input int exp_lat);
    int lat;
    s_valid = 1'b1; s_we = we; s_addr = addr; s_wdata = 8'hC3;
    lat = 0;
    do begin
      @(negedge clk);
      s_valid = 1'b0;
      lat++;
    end while (!s_done && lat < 50);
    chk(lat == exp_lat, "R9 one-cycle windows latency", lat, exp_lat);
    if (!we) chk(s_rdata == (addr[7:0] ^ 8'h5A), "R9 slow read data", int'(s_rdata), int'(addr[7:0] ^ 8'h5A));
  endtask

  initial begin
    #(150000 * 5);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin model_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    s_valid = 1'b0; s_we = 1'b0; s_addr = '0; s_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
    chk(!mem_dq_oe && req_ready && !rsp_done, "R1 bus/handshake idle",
        int'({mem_dq_oe, req_ready, rsp_done}), 2);
    mon_en = 1;

    op_run(1'b1, 21'h000000, 8'hA5);
    op_run(1'b1, 21'h1FFFFF, 8'h3C);
    op_run(1'b1, 21'h0ABC12, 8'h77);
    // Reads issued straight after a write's done: R8 back-to-back case
    op_run(1'b0, 21'h0ABC12, 8'h00);
    op_run(1'b0, 21'h000000, 8'h00);
    op_run(1'b0, 21'h1FFFFF, 8'h00);
    op_run(1'b1, 21'h000055, 8'h0F);
    op_run(1'b0, 21'h000055, 8'h00);

    // R2: a write request while busy must be ignored
    issue(1'b1, 21'h000033, 8'h5A);
    repeat (3) begin
      req_valid = 1'b1; req_we = 1'b1; req_addr = 21'h000044; req_wdata = 8'hEE;
      @(negedge clk);
      chk(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
    end
    req_valid = 1'b0;
    wait_done();
    op_run(1'b0, 21'h000044, 8'h00);
    op_run(1'b0, 21'h000033, 8'h00);
    repeat (3) @(negedge clk);
    mon_en = 0;

    // R9: minimum-one clamp in the slow build
    slow_op(1'b0, 21'h000012, 2);
    slow_op(1'b1, 21'h000020, 3);
    slow_op(1'b0, 21'h1FFFAB, 2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule